// File: doc/BRIEF.md
# USB Device Endpoint Configuration Register File

This block holds the software-visible configuration of a USB device controller with a bidirectional control endpoint (endpoint 0) and a parameterised set of numbered endpoints (five by default). It stores one global control word, one control word for endpoint 0, and one control word for each numbered endpoint. It also keeps a set of buffer-initialise flags, one for each endpoint buffer. Every stored field is also driven out as a status signal to the endpoint logic. The packet engines, DMA and the transceiver are outside this block.

Changes to the configuration are controlled by a function-reset bit in the global word. This bit comes out of system reset set. It is ORed with the system reset to form the function reset seen by the rest of the controller. Connection, data-toggle and power-mode bits, and each numbered endpoint's enable, type, direction and packet size, only take a write while the function reset is held. While it is held, every buffer-initialise flag is forced to 1. The flags stay set after software releases the reset, and software then clears them one at a time. The stall, DMA-enable and zero-length-packet bits, plus the resume and clock-stop bits, can be written at any time.

Access is through a single-cycle synchronous port. Software presents a word address, a write strobe and 16-bit write data. The read data register loads the addressed word on every clock.

Top module: `usbd_cfg_regs`

## Requirements
- R1: After system reset, the global word (address 0x0) reads 0x00A0, the endpoint 0 word (address 0x1) reads 0x0040, each numbered endpoint word (addresses 0x2 to 0x6) reads 0x0040, and the flag word (address 0x8) reads 0x007F.
- R2: The function-reset output is 1 while system reset is low or global bit 7 is 1. Writing 0 to bit 7 releases it, and writing 1 asserts it again.
- R3: While global bit 7 is 1, every flag in the flag word is forced to 1. Bit 0 is endpoint 0 IN, bit 1 is endpoint 0 OUT, and bit k+1 is endpoint k. The flags stay 1 after release. Once released, writing a 1 to a flag bit clears only that flag.
- R4: Global bits 5 (host disconnect), 1 (toggle mode) and 0 (self power) change on a write only while bit 7 is 1. Other writes leave them unchanged.
- R5: In a numbered endpoint word, bit 15 (enable), bits 14:13 (type), bit 12 (direction) and bits 8:0 (packet size) change on a write only while the function reset is 1.
- R6: Endpoint bits 11 (DMA enable) and 10 (zero-length enable) take a write at any time. Their values are kept across a change of the function-reset bit.
- R7: The endpoint 0 packet size (bits 6:0) is written only when global bit 7 and both endpoint 0 flags are 1, and only with values 1 to 64. Any other write keeps the old value.
- R8: Bit 9 of an endpoint word sets that endpoint's stall output and takes a write at any time. It always reads back as 0.
- R9: Unused bits of every word, and any unmapped address, read as 0.
- R10: While the host-disconnect bit is 1, the bus-reset input is masked from the bus-reset output.
- R11: Global bits 6 (resume) and 4 (clock stop) take a write at any time and drive their outputs directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| reg_addr | input | 4 | Word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data of the word addressed in the previous cycle |
| bus_rst_i | input | 1 | Bus reset detected by the line interface |
| bus_rst_o | output | 1 | Bus reset passed on to the controller |
| func_rst_o | output | 1 | Function reset (software bit OR system reset) |
| host_disc_o | output | 1 | Host disconnect request |
| resume_o | output | 1 | Remote resume request |
| clk_stop_o | output | 1 | Operating clock stop request |
| tog_mode_o | output | 1 | Interrupt data-toggle mode |
| self_pwr_o | output | 1 | Self-powered indication |
| ep0_size_o | output | 7 | Endpoint 0 maximum packet size |
| ep0_stall_o | output | 1 | Endpoint 0 stall |
| ep_en_o | output | 5 | Numbered endpoint enables, bit k-1 is endpoint k |
| ep_type_o | output | 10 | Transfer types, two bits per endpoint |
| ep_dir_o | output | 5 | Directions |
| ep_size_o | output | 45 | Packet sizes, nine bits per endpoint |
| ep_dma_o | output | 5 | DMA enables |
| ep_null_o | output | 5 | Zero-length packet enables |
| ep_stall_o | output | 5 | Stall outputs |
| binit_o | output | 7 | Buffer-initialise flags |

## Verification
The assertions assume that software never starts a configuration write in the cycle right after setting the function-reset bit. The endpoint 0 size gate reads the flags, and the flags lag that bit by one clock. The stimulus keeps idle cycles or a read between re-asserting the reset and any endpoint 0 write. The assertions also assume that the system reset is applied from time zero. The bench drives reset low before the first clock edge and changes inputs only on falling edges.

// File: rtl/usbd_cfg_pkg.sv
// Package: shared types and the register address map of the USB device
// configuration register file. Assumes word addressing on a 4-bit address.
package usbd_cfg_pkg;

    // Fields held in the global control word.
    typedef struct packed {
        logic frst;      // function reset, bit 7
        logic resume;    // resume request, bit 6
        logic hdisc;     // host disconnect, bit 5
        logic clkstop;   // clock stop, bit 4
        logic tog;       // toggle mode, bit 1
        logic pwr;       // self power, bit 0
    } gctl_t;

    localparam int GCTL_ADDR = 0;
    localparam int EP0_ADDR  = 1;
    localparam int EPN_BASE  = 2;   // endpoint k sits at EPN_BASE + k - 1

endpackage

// File: rtl/usbd_glob_ctl.sv
// Module: global control word. Reset, resume and clock-stop bits are always
// writable. Connection, toggle and power bits change only while the function
// reset bit is set. Assumes wr_i is already address-decoded.
module usbd_glob_ctl
    import usbd_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_i,
    input  gctl_t wval_i,
    output gctl_t gctl_o
);

    gctl_t q;

    // Purpose: store global bits, gating configuration bits on the reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{frst: 1'b1, resume: 1'b0, hdisc: 1'b1, clkstop: 1'b0,
                   tog: 1'b0, pwr: 1'b0};
        end else if (wr_i) begin
            q.frst    <= wval_i.frst;
            q.resume  <= wval_i.resume;
            q.clkstop <= wval_i.clkstop;
            if (q.frst) begin
                q.hdisc <= wval_i.hdisc;
                q.tog   <= wval_i.tog;
                q.pwr   <= wval_i.pwr;
            end
        end
    end

    assign gctl_o = q;

endmodule

// File: rtl/usbd_binit_flags.sv
// Module: buffer-initialise flags. Forced to all ones while the function reset
// is set. Once it is released, each flag is cleared by writing a one to its bit.
module usbd_binit_flags #(
    parameter int NFLAG = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frst_i,
    input  logic             clr_wr_i,
    input  logic [NFLAG-1:0] clr_bits_i,
    output logic [NFLAG-1:0] flags_o
);

    // Purpose: hold flags, force them on function reset, clear on write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o <= '1;
        end else if (frst_i) begin
            flags_o <= '1;
        end else if (clr_wr_i) begin
            flags_o <= flags_o & ~clr_bits_i;
        end
    end

endmodule

// File: rtl/usbd_ep0_ctl.sv
// Module: endpoint 0 control word. The packet size takes only legal values
// (1 to MAX_PKT) and only while cfg_ok_i is high. Stall is always writable.
module usbd_ep0_ctl #(
    parameter int SIZE_W  = 7,
    parameter int MAX_PKT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              cfg_ok_i,
    input  logic              stall_w_i,
    input  logic [SIZE_W-1:0] size_w_i,
    output logic [SIZE_W-1:0] size_o,
    output logic              stall_o
);

    localparam logic [SIZE_W-1:0] MAXV = SIZE_W'(MAX_PKT);

    logic legal;

    // Purpose: check that the written size is within 1..MAX_PKT.
    always_comb legal = (size_w_i != '0) && (size_w_i <= MAXV);

    // Purpose: store size and stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_o  <= MAXV;
            stall_o <= 1'b0;
        end else if (wr_i) begin
            stall_o <= stall_w_i;
            if (cfg_ok_i && legal) size_o <= size_w_i;
        end
    end

endmodule

// File: rtl/usbd_epn_ctl.sv
// Module: control word of one numbered endpoint. Enable, type, direction and
// size are gated by the function reset. DMA, zero-length and stall bits are
// always writable. Upper write bits arrive as [15:9] of the bus word.
module usbd_epn_ctl #(
    parameter int SIZE_W   = 9,
    parameter int SIZE_RST = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              frst_i,
    input  logic [6:0]        hi_w_i,
    input  logic [SIZE_W-1:0] size_w_i,
    output logic              en_o,
    output logic [1:0]        type_o,
    output logic              dir_o,
    output logic              dma_o,
    output logic              null_o,
    output logic              stall_o,
    output logic [SIZE_W-1:0] size_o
);

    // Purpose: store endpoint fields with configuration gating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o    <= 1'b0;
            type_o  <= 2'b00;
            dir_o   <= 1'b0;
            dma_o   <= 1'b0;
            null_o  <= 1'b0;
            stall_o <= 1'b0;
            size_o  <= SIZE_W'(SIZE_RST);
        end else if (wr_i) begin
            dma_o   <= hi_w_i[2];
            null_o  <= hi_w_i[1];
            stall_o <= hi_w_i[0];
            if (frst_i) begin
                en_o   <= hi_w_i[6];
                type_o <= hi_w_i[5:4];
                dir_o  <= hi_w_i[3];
                size_o <= size_w_i;
            end
        end
    end

endmodule

// File: rtl/usbd_cfg_regs.sv
// Module: top of the USB device configuration register file. Decodes the
// register port, instantiates the global word, the endpoint 0 word, one word
// per numbered endpoint and the buffer-initialise flags, and registers the
// read data. Assumes N_EP + 3 addresses fit in ADDR_W bits and EP_SIZE_W <= 9.
module usbd_cfg_regs
    import usbd_cfg_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int N_EP      = 5,
    parameter int EP_SIZE_W = 9,
    parameter int EP0_MAX   = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic                      reg_wr,
    input  logic [15:0]               reg_wdata,
    output logic [15:0]               reg_rdata,
    input  logic                      bus_rst_i,
    output logic                      bus_rst_o,
    output logic                      func_rst_o,
    output logic                      host_disc_o,
    output logic                      resume_o,
    output logic                      clk_stop_o,
    output logic                      tog_mode_o,
    output logic                      self_pwr_o,
    output logic [6:0]                ep0_size_o,
    output logic                      ep0_stall_o,
    output logic [N_EP-1:0]           ep_en_o,
    output logic [2*N_EP-1:0]         ep_type_o,
    output logic [N_EP-1:0]           ep_dir_o,
    output logic [N_EP*EP_SIZE_W-1:0] ep_size_o,
    output logic [N_EP-1:0]           ep_dma_o,
    output logic [N_EP-1:0]           ep_null_o,
    output logic [N_EP-1:0]           ep_stall_o,
    output logic [N_EP+1:0]           binit_o
);

    localparam int NFLAG     = N_EP + 2;
    localparam int FLAG_ADDR = EPN_BASE + N_EP + 1;

    gctl_t     gctl;
    gctl_t     gwval;
    logic      wr_gctl, wr_ep0, wr_flag;
    logic      ep0_ok;
    logic [15:0] rd_next;

    // Purpose: decode writes to the fixed-address words.
    always_comb begin
        wr_gctl = reg_wr && (reg_addr == ADDR_W'(GCTL_ADDR));
        wr_ep0  = reg_wr && (reg_addr == ADDR_W'(EP0_ADDR));
        wr_flag = reg_wr && (reg_addr == ADDR_W'(FLAG_ADDR));
    end

    // Purpose: pick global-word fields out of the write data.
    always_comb begin
        gwval.frst    = reg_wdata[7];
        gwval.resume  = reg_wdata[6];
        gwval.hdisc   = reg_wdata[5];
        gwval.clkstop = reg_wdata[4];
        gwval.tog     = reg_wdata[1];
        gwval.pwr     = reg_wdata[0];
    end

    usbd_glob_ctl u_glob (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_gctl),
        .wval_i (gwval),
        .gctl_o (gctl)
    );

    usbd_binit_flags #(.NFLAG(NFLAG)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .frst_i     (gctl.frst),
        .clr_wr_i   (wr_flag),
        .clr_bits_i (reg_wdata[NFLAG-1:0]),
        .flags_o    (binit_o)
    );

    // Purpose: endpoint 0 size needs the reset bit and both endpoint 0 flags.
    always_comb ep0_ok = gctl.frst && binit_o[0] && binit_o[1];

    usbd_ep0_ctl #(.SIZE_W(7), .MAX_PKT(EP0_MAX)) u_ep0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_ep0),
        .cfg_ok_i  (ep0_ok),
        .stall_w_i (reg_wdata[9]),
        .size_w_i  (reg_wdata[6:0]),
        .size_o    (ep0_size_o),
        .stall_o   (ep0_stall_o)
    );

    for (genvar k = 0; k < N_EP; k++) begin : g_ep
        logic wr_k;
        // Purpose: decode a write to this endpoint's word.
        always_comb wr_k = reg_wr && (reg_addr == ADDR_W'(EPN_BASE + k));

        usbd_epn_ctl #(.SIZE_W(EP_SIZE_W), .SIZE_RST(64)) u_ep (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (wr_k),
            .frst_i   (gctl.frst),
            .hi_w_i   (reg_wdata[15:9]),
            .size_w_i (reg_wdata[EP_SIZE_W-1:0]),
            .en_o     (ep_en_o[k]),
            .type_o   (ep_type_o[2*k +: 2]),
            .dir_o    (ep_dir_o[k]),
            .dma_o    (ep_dma_o[k]),
            .null_o   (ep_null_o[k]),
            .stall_o  (ep_stall_o[k]),
            .size_o   (ep_size_o[EP_SIZE_W*k +: EP_SIZE_W])
        );
    end

    // Purpose: form the read word for the current address; stall reads 0.
    always_comb begin
        rd_next = '0;
        if (reg_addr == ADDR_W'(GCTL_ADDR)) begin
            rd_next[7:4] = {gctl.frst, gctl.resume, gctl.hdisc, gctl.clkstop};
            rd_next[1:0] = {gctl.tog, gctl.pwr};
        end
        if (reg_addr == ADDR_W'(EP0_ADDR)) rd_next[6:0] = ep0_size_o;
        if (reg_addr == ADDR_W'(FLAG_ADDR)) rd_next[NFLAG-1:0] = binit_o;
        for (int k = 0; k < N_EP; k++) begin
            if (reg_addr == ADDR_W'(EPN_BASE + k)) begin
                rd_next[15]    = ep_en_o[k];
                rd_next[14:13] = ep_type_o[2*k +: 2];
                rd_next[12]    = ep_dir_o[k];
                rd_next[11]    = ep_dma_o[k];
                rd_next[10]    = ep_null_o[k];
                rd_next[EP_SIZE_W-1:0] = ep_size_o[EP_SIZE_W*k +: EP_SIZE_W];
            end
        end
    end

    // Purpose: register the read data every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else        reg_rdata <= rd_next;
    end

    // Purpose: drive status outputs and mask bus reset while disconnected.
    always_comb begin
        func_rst_o  = gctl.frst || !rst_n;
        host_disc_o = gctl.hdisc;
        resume_o    = gctl.resume;
        clk_stop_o  = gctl.clkstop;
        tog_mode_o  = gctl.tog;
        self_pwr_o  = gctl.pwr;
        bus_rst_o   = bus_rst_i && !gctl.hdisc;
    end

endmodule

// File: rtl/usbd_cfg_chk.sv
// Module: assertion checker bound to usbd_cfg_regs. Assumes system reset is
// low from time zero.
module usbd_cfg_chk #(
    parameter int N_EP      = 5,
    parameter int EP_SIZE_W = 9
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [15:0]               reg_rdata,
    input logic                      bus_rst_o,
    input logic                      func_rst_o,
    input logic                      host_disc_o,
    input logic                      tog_mode_o,
    input logic                      self_pwr_o,
    input logic [6:0]                ep0_size_o,
    input logic [N_EP-1:0]           ep_en_o,
    input logic [2*N_EP-1:0]         ep_type_o,
    input logic [N_EP-1:0]           ep_dir_o,
    input logic [N_EP*EP_SIZE_W-1:0] ep_size_o,
    input logic [N_EP+1:0]           binit_o
);

    p_sysrst_or_r2: assert property (@(posedge clk) !rst_n |-> func_rst_o);

    p_flags_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        func_rst_o |=> (&binit_o));

    p_gctl_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({host_disc_o, tog_mode_o, self_pwr_o}) |-> $past(func_rst_o));

    p_ep_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ep_en_o, ep_type_o, ep_dir_o, ep_size_o}) |-> $past(func_rst_o));

    p_ep0_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ep0_size_o != 7'd0) && (ep0_size_o <= 7'd64));

    p_ep0_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ep0_size_o) |-> $past(func_rst_o));

    p_stall_rd0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[9] == 1'b0);

    p_busrst_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_disc_o |-> !bus_rst_o);

endmodule

bind usbd_cfg_regs usbd_cfg_chk #(.N_EP(N_EP), .EP_SIZE_W(EP_SIZE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rdata   (reg_rdata),
    .bus_rst_o   (bus_rst_o),
    .func_rst_o  (func_rst_o),
    .host_disc_o (host_disc_o),
    .tog_mode_o  (tog_mode_o),
    .self_pwr_o  (self_pwr_o),
    .ep0_size_o  (ep0_size_o),
    .ep_en_o     (ep_en_o),
    .ep_type_o   (ep_type_o),
    .ep_dir_o    (ep_dir_o),
    .ep_size_o   (ep_size_o),
    .binit_o     (binit_o)
);

// File: tb/sim_usbd_cfg_regs.sv
// Directed bench for usbd_cfg_regs: one task per scenario, each checking itself.
module sim_usbd_cfg_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        bus_rst_i = 1'b0;
    logic        bus_rst_o, func_rst_o, host_disc_o, resume_o, clk_stop_o;
    logic        tog_mode_o, self_pwr_o, ep0_stall_o;
    logic [6:0]  ep0_size_o;
    logic [4:0]  ep_en_o, ep_dir_o, ep_dma_o, ep_null_o, ep_stall_o;
    logic [9:0]  ep_type_o;
    logic [44:0] ep_size_o;
    logic [6:0]  binit_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    usbd_cfg_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_rst_i(bus_rst_i),
        .bus_rst_o(bus_rst_o), .func_rst_o(func_rst_o), .host_disc_o(host_disc_o),
        .resume_o(resume_o), .clk_stop_o(clk_stop_o), .tog_mode_o(tog_mode_o),
        .self_pwr_o(self_pwr_o), .ep0_size_o(ep0_size_o), .ep0_stall_o(ep0_stall_o),
        .ep_en_o(ep_en_o), .ep_type_o(ep_type_o), .ep_dir_o(ep_dir_o),
        .ep_size_o(ep_size_o), .ep_dma_o(ep_dma_o), .ep_null_o(ep_null_o),
        .ep_stall_o(ep_stall_o), .binit_o(binit_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b0;
        @(negedge clk);
        chk(req, reg_rdata, exp);
    endtask

    task automatic t_reset;
        chk("R1 flag outputs", {9'd0, binit_o}, 16'h007F);
        chk("R2 func reset after reset", {15'd0, func_rst_o}, 16'h0001);
        rd_chk("R1 global word", 4'h0, 16'h00A0);
        rd_chk("R1 ep0 word", 4'h1, 16'h0040);
        rd_chk("R1 ep5 word", 4'h6, 16'h0040);
        rd_chk("R1 flag word", 4'h8, 16'h007F);
        bus_rst_i = 1'b1;
        @(negedge clk);
        chk("R10 bus reset masked", {15'd0, bus_rst_o}, 16'h0000);
    endtask

    task automatic t_reserved;
        wr(4'h0, 16'hFFFF);
        rd_chk("R9 global reserved bits", 4'h0, 16'h00F3);
        rd_chk("R9 unmapped 0x7", 4'h7, 16'h0000);
        rd_chk("R9 unmapped 0xF", 4'hF, 16'h0000);
    endtask

    task automatic t_config;
        wr(4'h0, 16'h0083);
        rd_chk("R4 gated bits while held", 4'h0, 16'h0083);
        chk("R10 bus reset passes", {15'd0, bus_rst_o}, 16'h0001);
        wr(4'h1, 16'h0008);
        rd_chk("R7 ep0 size legal", 4'h1, 16'h0008);
        wr(4'h2, 16'hF010);
        rd_chk("R5 ep1 config while held", 4'h2, 16'hF010);
        chk("R5 ep1 size out", {7'd0, ep_size_o[8:0]}, 16'h0010);
        chk("R5 ep1 enable/dir out", {14'd0, ep_en_o[0], ep_dir_o[0]}, 16'h0003);
    endtask

    task automatic t_ep0_limits;
        wr(4'h1, 16'h0000);
        rd_chk("R7 ep0 zero ignored", 4'h1, 16'h0008);
        wr(4'h1, 16'h0041);
        rd_chk("R7 ep0 65 ignored", 4'h1, 16'h0008);
        wr(4'h1, 16'h007F);
        rd_chk("R7 ep0 127 ignored", 4'h1, 16'h0008);
        wr(4'h1, 16'h0040);
        rd_chk("R7 ep0 64 accepted", 4'h1, 16'h0040);
    endtask

    task automatic t_release;
        wr(4'h0, 16'h0003);
        chk("R2 released", {15'd0, func_rst_o}, 16'h0000);
        rd_chk("R3 flags kept after release", 4'h8, 16'h007F);
        wr(4'h0, 16'h0020);
        rd_chk("R4 gated bits ignored", 4'h0, 16'h0003);
        chk("R10 still connected", {15'd0, bus_rst_o}, 16'h0001);
    endtask

    task automatic t_runtime;
        wr(4'h2, 16'h0005);
        rd_chk("R5 ep1 config ignored", 4'h2, 16'hF010);
        wr(4'h1, 16'h0020);
        rd_chk("R7 ep0 size ignored when released", 4'h1, 16'h0040);
        wr(4'h2, 16'h0E00);
        rd_chk("R6 dma/null writable, R8 stall reads 0", 4'h2, 16'hFC10);
        chk("R8 ep1 stall out", {15'd0, ep_stall_o[0]}, 16'h0001);
        chk("R6 ep1 dma/null out", {14'd0, ep_dma_o[0], ep_null_o[0]}, 16'h0003);
        wr(4'h1, 16'h0200);
        chk("R8 ep0 stall out", {15'd0, ep0_stall_o}, 16'h0001);
        rd_chk("R8 ep0 stall reads 0", 4'h1, 16'h0040);
        wr(4'h0, 16'h0053);
        rd_chk("R11 resume/clkstop writable", 4'h0, 16'h0053);
        chk("R11 outputs", {14'd0, resume_o, clk_stop_o}, 16'h0003);
        wr(4'h0, 16'h0003);
        chk("R11 cleared", {14'd0, resume_o, clk_stop_o}, 16'h0000);
    endtask

    task automatic t_flag_clear;
        wr(4'h8, 16'h0004);
        rd_chk("R3 clear ep1 flag", 4'h8, 16'h007B);
        wr(4'h8, 16'h0003);
        rd_chk("R3 clear ep0 flags", 4'h8, 16'h0078);
    endtask

    task automatic t_reassert;
        wr(4'h0, 16'h0083);
        chk("R2 asserted again", {15'd0, func_rst_o}, 16'h0001);
        @(negedge clk);
        rd_chk("R3 flags forced", 4'h8, 16'h007F);
        rd_chk("R6 dma/null kept", 4'h2, 16'hFC10);
        wr(4'h1, 16'h0010);
        rd_chk("R7 ep0 size with flags set", 4'h1, 16'h0010);
        chk("R8 ep0 stall rewritten 0", {15'd0, ep0_stall_o}, 16'h0000);
    endtask

    task automatic t_sysreset;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R2 system reset ORed", {15'd0, func_rst_o}, 16'h0001);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R1 global after reset", 4'h0, 16'h00A0);
        rd_chk("R1 ep1 after reset", 4'h2, 16'h0040);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reserved();
        t_config();
        t_ep0_limits();
        t_release();
        t_runtime();
        t_flag_clear();
        t_reassert();
        t_sysreset();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule